// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Register Slave

This block is a target device on a two-wire serial bus (I2C-compatible). It gives an external bus master read and write access to a small bank of byte-wide control registers. The contents of the bank are driven out in parallel to the logic that uses them. The block runs entirely from a fast system clock. It samples both bus lines through synchronizers, finds START and STOP conditions and clock edges, and only ever pulls SDA low. It never drives SDA high. The pull-up resistors outside the block restore the high level.

The 7-bit device address has a fixed upper part. Its lowest bit comes from a strap input, so two identical slaves can share one bus. A write transaction first loads a register pointer. Every further byte is then stored at the pointer, and the pointer advances by one after each byte, so one transaction can fill a run of consecutive registers. A read transaction returns the register at the pointer and advances it after each byte, for as long as the master acknowledges. A repeated START leaves the pointer unchanged. Because of this, a master can set the pointer in a write and then read from that point without sending a STOP in between.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is asserted and just after it, SDA is released (`sda_oe` = 0), every register reads 0 and the pointer is 0.
- R2: SDA falling while SCL is high is a START. It aborts any transfer and begins reception of an address byte. SDA rising while SCL is high is a STOP. It releases SDA and returns the block to idle.
- R3: The block changes its SDA drive only while SCL is low, after a detected SCL falling edge, or when a START or STOP has just been detected.
- R4: The first byte after a START is received MSB first as seven address bits followed by a direction bit (0 = write, 1 = read). With `addr_sel` = 0 the block answers 0xC0 (write) and 0xC1 (read). With `addr_sel` = 1 it answers 0xC2 and 0xC3. On a match it pulls SDA low through the ninth SCL clock.
- R5: After any other address byte the block gives no ACK. It does not drive SDA and changes no register until the next START.
- R6: In a write, the first data byte sets the pointer to the byte's value modulo the register count. This byte is acknowledged.
- R7: Each following write byte is acknowledged and stored at the pointer, which then advances by one and wraps from the last register to register 0. Register i appears on `regs_o[8*i+7:8*i]`.
- R8: In a read, the block sends the register at the pointer MSB first, changing SDA after each SCL falling edge. The pointer advances by one after every byte sent. When the master acknowledges (SDA low on the ninth clock), the next register follows.
- R9: When the master leaves SDA high on the ninth clock of a read byte, the block releases SDA and sends nothing more until a START.
- R10: A repeated START inside a transaction restarts address matching and keeps the pointer value.
- R11: Bus lines pass through a synchronizer of `SYNC_STAGES` flops. Data is sampled on the detected SCL rising edge. This requires a system clock at least 16 times the SCL rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| addr_sel | input | 1 | Strap selecting address bit 0 (0xC0/0xC1 or 0xC2/0xC3) |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release |
| regs_o | output | 8*NREG | Register bank contents, register i in bits 8i+7..8i |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it forms a START or a STOP. They also assume that each SCL high and low phase lasts longer than the synchronizer delay, so edges on the two lines never appear in the same sampled cycle, and that the master never issues a START or STOP while the slave is holding SDA low. The stimulus meets all of this. Every bus action lasts ten system clocks, the master moves SDA ten clocks after SCL falls, and it issues START and STOP only when the slave has released the line. A bus monitor in the stimulus also counts every change of `sda_oe` that occurs while the real SCL is high.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } slv_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } slv_phase_t;

  // 7-bit device address: fixed upper six bits, strap in bit 0
  function automatic logic [6:0] dev_addr(input logic [6:0] base, input logic strap);
    return {base[6:1], strap};
  endfunction

  // pointer loaded from a received byte
  function automatic int ptr_load(input int value, input int nreg);
    return value % nreg;
  endfunction

  // pointer advance with wrap
  function automatic int ptr_step(input int p, input int nreg);
    return (p + 1 >= nreg) ? 0 : p + 1;
  endfunction

  // SDA edge while SCL held high
  function automatic logic bus_cond(input logic scl_lvl, input logic scl_rise,
                                    input logic sda_edge);
    return scl_lvl & ~scl_rise & sda_edge;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NREG = 8,
  parameter int PW   = 3,
  parameter int BW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [PW-1:0]      waddr,
  input  logic [BW-1:0]      wdata,
  input  logic [PW-1:0]      raddr,
  output logic [BW-1:0]      rdata,
  output logic [NREG*BW-1:0] flat_o
);
  logic [BW-1:0] mem_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat_o[g*BW +: BW] = mem_q[g];
  end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2c_regslave_pkg::*;
#(
  parameter int         NREG        = 8,
  parameter logic [6:0] ADDR_BASE   = 7'h60,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int BW = 8;

  // line conditioning: index 1 = SCL, index 0 = SDA
  logic [1:0] line_raw, line_lvl, line_rise, line_fall;
  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_raw[g]),
      .lvl_o  (line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  // named bus events
  logic scl_lvl, scl_rise, scl_fall, sda_lvl;
  logic start_det, stop_det;
  assign scl_lvl   = line_lvl[1];
  assign scl_rise  = line_rise[1];
  assign scl_fall  = line_fall[1];
  assign sda_lvl   = line_lvl[0];
  assign start_det = bus_cond(scl_lvl, scl_rise, line_fall[0]);
  assign stop_det  = bus_cond(scl_lvl, scl_rise, line_rise[0]);

  // transaction state
  slv_state_t    st_q;
  slv_phase_t    ph_q;
  logic          rw_q;
  logic [3:0]    cnt_q;
  logic [BW-1:0] sh_q;
  logic          mack_q;
  logic [PW-1:0] ptr_q;
  logic [BW-1:0] rd_data;

  logic byte_end, addr_hit, wr_en, tx_done, st_idle;
  assign byte_end = (st_q == ST_RX) && scl_fall && (cnt_q == 4'd8);
  assign addr_hit = (sh_q[7:1] == dev_addr(ADDR_BASE, addr_sel));
  assign wr_en    = byte_end && (ph_q == PH_DATA);
  assign tx_done  = (st_q == ST_TX) && scl_fall && (cnt_q == 4'd8);
  assign st_idle  = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_ADDR;
      rw_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      mack_q <= 1'b0;
    end else if (start_det) begin
      st_q  <= ST_RX;
      ph_q  <= PH_ADDR;
      cnt_q <= '0;
    end else if (stop_det) begin
      st_q <= ST_IDLE;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_q  <= {sh_q[BW-2:0], sda_lvl};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_end) begin
            if (ph_q == PH_ADDR) begin
              if (addr_hit) begin
                rw_q <= sh_q[0];
                st_q <= ST_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end else begin
              st_q <= ST_ACK;
              if (ph_q == PH_PTR) ph_q <= PH_DATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (ph_q == PH_ADDR && rw_q) begin
              st_q <= ST_TX;
              sh_q <= rd_data;
              ph_q <= PH_DATA;
            end else begin
              st_q <= ST_RX;
              if (ph_q == PH_ADDR) ph_q <= PH_PTR;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && cnt_q != 4'd8) cnt_q <= cnt_q + 4'd1;
          else if (tx_done)              st_q  <= ST_MACK;
          else if (scl_fall && cnt_q != 4'd0) sh_q <= {sh_q[BW-2:0], 1'b0};
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_q  <= ST_TX;
              sh_q  <= rd_data;
              cnt_q <= '0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // register pointer: survives START, loaded by the first write byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ptr_q <= '0;
    else if (byte_end && ph_q == PH_PTR) ptr_q <= PW'(ptr_load(int'(sh_q), NREG));
    else if (wr_en || tx_done)           ptr_q <= PW'(ptr_step(int'(ptr_q), NREG));
  end

  i2c_reg_bank #(.NREG(NREG), .PW(PW), .BW(BW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en),
    .waddr  (ptr_q),
    .wdata  (sh_q),
    .raddr  (ptr_q),
    .rdata  (rd_data),
    .flat_o (regs_o)
  );

  // open-drain drive: ACK slot, or a zero bit while transmitting
  assign sda_oe = (st_q == ST_ACK) || ((st_q == ST_TX) && !sh_q[BW-1]);

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
  parameter int NREG = 8,
  parameter int PW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_rise,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input logic          wr_en,
  input logic          rd_mode,
  input logic          st_idle,
  input logic [PW-1:0] ptr
);
  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det)); // R3

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det, scl_rise, scl_fall})); // R2

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe); // R2

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_idle && !sda_oe)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sda_oe); // R5

  AST_WRITE_IN_WRITE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_mode); // R7

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (int'(ptr) == ((int'($past(ptr)) + 1 >= NREG) ? 0 : int'($past(ptr)) + 1))); // R7
endmodule

bind i2c_regslave i2c_regslave_chk #(.NREG(NREG), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .rd_mode   (rw_q),
  .st_idle   (st_idle),
  .ptr       (ptr_q)
);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda = sda_m & ~sda_oe;

  always #10 clk = ~clk; // 50 MHz

  i2c_regslave #(.NREG(NREG)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda),
    .addr_sel (addr_sel),
    .sda_oe   (sda_oe),
    .regs_o   (regs_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int r3_viol = 0;
  bit run_on = 1'b0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  // R3 monitor: slave drive must never move while the real SCL is high
  always @(sda_oe) if (run_on && scl) r3_viol++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl = 1'b1; q(); ack = ~sda; q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda; q(); scl = 1'b0;
    end
    q(); sda_m = mack ? 1'b0 : 1'b1; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, 32'(regs_o[i*8 +: 8]), 32'(model[i]));
  endtask

  // {strap, address byte, pointer byte, data byte, expected ACK}
  localparam int NVEC = 7;
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 8'hC0, 8'h02, 8'hA5, 1'b1},
    {1'b1, 8'hC2, 8'h05, 8'h3C, 1'b1},
    {1'b0, 8'hC2, 8'h01, 8'hFF, 1'b0},
    {1'b1, 8'hC0, 8'h03, 8'h77, 1'b0},
    {1'b1, 8'hC2, 8'h0F, 8'h81, 1'b1},
    {1'b0, 8'hC0, 8'h00, 8'h11, 1'b1},
    {1'b0, 8'hA0, 8'h04, 8'h55, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] rb;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;

    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 sda_oe in reset", 32'(sda_oe), 0);
    check_bank("R1 registers in reset");
    rst_n = 1'b1;
    q();
    check("R1 sda_oe after reset", 32'(sda_oe), 0);
    run_on = 1'b1;

    // vector table: single-register writes, matching and foreign addresses
    for (int v = 0; v < NVEC; v++) begin
      logic exp_ack;
      addr_sel = VEC[v][25];
      exp_ack  = VEC[v][0];
      bus_start();
      send_byte(VEC[v][24:17], a);
      check("R4 R5 address ack", 32'(a), 32'(exp_ack));
      send_byte(VEC[v][16:9], a);
      check("R6 pointer byte ack", 32'(a), 32'(exp_ack));
      send_byte(VEC[v][8:1], a);
      check("R7 data byte ack", 32'(a), 32'(exp_ack));
      bus_stop();
      if (exp_ack) model[int'(VEC[v][16:9]) % NREG] = VEC[v][8:1];
      check_bank("R5 R6 bank after table write");
    end

    // R7: burst write with wrap 6,7,0
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hC0, a); send_byte(8'h06, a);
    send_byte(8'h10, a); check("R7 burst byte 0 ack", 32'(a), 1);
    send_byte(8'h20, a); check("R7 burst byte 1 ack", 32'(a), 1);
    send_byte(8'h30, a); check("R7 burst wrap byte ack", 32'(a), 1);
    bus_stop();
    model[6] = 8'h10; model[7] = 8'h20; model[0] = 8'h30;
    check_bank("R7 bank after burst");

    // R10 + R8: set pointer, repeated START, read three bytes
    bus_start();
    send_byte(8'hC0, a); send_byte(8'h06, a);
    bus_start();
    send_byte(8'hC1, a); check("R10 read address ack after Sr", 32'(a), 1);
    recv_byte(rb, 1'b1); check("R10 R11 read byte at kept pointer", 32'(rb), 32'(model[6]));
    recv_byte(rb, 1'b1); check("R8 read next register", 32'(rb), 32'(model[7]));
    recv_byte(rb, 1'b0); check("R8 read wraps to register 0", 32'(rb), 32'(model[0]));
    check("R9 released after master NACK", 32'(sda_oe), 0);
    recv_byte(rb, 1'b0); check("R9 no data after NACK", 32'(rb), 32'hFF);
    bus_stop();

    // R8: pointer keeps advancing across read transactions (now at 1)
    bus_start();
    send_byte(8'hC1, a);
    recv_byte(rb, 1'b0); check("R8 read continues at register 1", 32'(rb), 32'(model[1]));
    bus_stop();
    bus_start();
    send_byte(8'hC1, a);
    recv_byte(rb, 1'b0); check("R8 read continues at register 2", 32'(rb), 32'(model[2]));
    bus_stop();

    // R4: strap high answers 0xC2/0xC3, not 0xC1
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'hC1, a); check("R4 strap high rejects 0xC1", 32'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'hC2, a); send_byte(8'h05, a);
    bus_start();
    send_byte(8'hC3, a); check("R4 strap high read ack", 32'(a), 1);
    recv_byte(rb, 1'b0); check("R4 R8 strap high read data", 32'(rb), 32'(model[5]));
    bus_stop();

    // R2: STOP straight after address leaves bank intact and SDA free
    addr_sel = 1'b0;
    bus_start();
    send_byte(8'hC0, a);
    bus_stop();
    check("R2 released after STOP", 32'(sda_oe), 0);
    check_bank("R2 bank unchanged by empty write");

    // R2: START after a foreign address re-engages matching
    bus_start();
    send_byte(8'hB4, a); check("R5 foreign address not acked", 32'(a), 0);
    bus_start();
    send_byte(8'hC0, a); check("R2 START after foreign address", 32'(a), 1);
    send_byte(8'h03, a); send_byte(8'h9E, a);
    bus_stop();
    model[3] = 8'h9E;
    check_bank("R2 write after repeated START");

    check("R3 drive changes while SCL high", 32'(r3_viol), 0);

    // R1: reset in the middle of a transfer
    bus_start();
    send_byte(8'hC0, a);
    run_on = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sda_oe on mid-transfer reset", 32'(sda_oe), 0);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    check_bank("R1 bank cleared by reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule